// File: doc/BRIEF.md
# Dual-Width Read-Only Memory with Shared LSB Pin

This block models a read-only array whose stored entries are 32 bits wide. A static mode input chooses how the array is presented. In wide mode every entry appears whole on a 32-bit data output. In narrow mode the array looks like twice as many 16-bit words. The pin that would otherwise carry data bit 31 becomes the lowest address bit. It chooses which half of the addressed entry is presented on the low 16-bit lane.

The tri-state data pins are modelled as a 32-bit data vector plus three output enables: one for the low lane (bits 15:0), one for bits 30:16, and one for bit 31. Two active-low controls gate the output. A chip select in the high state floats everything. With the chip selected, a high output-enable control also floats everything. The array is never written.

Contents come from a closed-form function of the entry index and a seed parameter. The read is registered, so all outputs reflect the inputs sampled at the previous rising clock edge. This lets the array map onto block memory. All control pins are plain levels, because the block has no streaming interface.

Top module: `dual_width_rom`

## Requirements
- R1: When `ce_n_i` was high at the previous rising edge, all three output enables are low and `data_o` is all zero.
- R2: When `ce_n_i` was low and `oe_n_i` was high at the previous rising edge, all three output enables are low and `data_o` is all zero.
- R3: Wide mode (`wide_i` = 1) with both controls low drives all three output enables high. `data_o` then equals entry(`addr_i`), where entry(a) = {16-bit (a*37+11), 16-bit (a*101+7)} XOR `SEED`, with the first field in bits 31:16.
- R4: Narrow mode (`wide_i` = 0) with both controls low drives the low-lane enable high. `data_o[15:0]` is bits 15:0 of entry(`addr_i`) when `lsb_i` = 0, and bits 31:16 when `lsb_i` = 1.
- R5: In narrow mode, the bits 30:16 enable and the bit-31 enable are low, and `data_o[31:16]` is zero.
- R6: In wide mode the value of `lsb_i` has no effect on any output.
- R7: Outputs change only at a rising clock edge, one cycle after the inputs they reflect are sampled. Between edges they hold the previous result.
- R8: While `rst_n` is low, all output enables are low and `data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Entry index (address bits above the shared LSB) |
| lsb_i | input | 1 | Shared pin seen as the lowest address bit in narrow mode |
| ce_n_i | input | 1 | Active-low chip select |
| oe_n_i | input | 1 | Active-low output enable |
| wide_i | input | 1 | Mode: 1 = 32-bit entries, 0 = 16-bit words |
| data_o | output | 32 | Data value; zero on any lane whose enable is low |
| lo_oe_o | output | 1 | Drive enable for bits 15:0 |
| mid_oe_o | output | 1 | Drive enable for bits 30:16 |
| top_oe_o | output | 1 | Drive enable for bit 31 (shared pin) |

## Verification
The hardest situation to reach from the ports is this one: the shared pin is toggled in wide mode while the read stays the same, and nothing on the outputs may move. The same stimulus in narrow mode must swap the low lane. The bench sweeps every entry index under every combination of mode, shared bit and the two controls. Each pair of vectors with opposite shared-bit values is therefore compared in both modes. Latency is confirmed by reading the outputs just after new inputs are applied and before the next edge, when they must still show the prior result.

// File: rtl/dwr_pkg.sv
package dwr_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned HW = 16;

  typedef logic [DW-1:0] entry_t;
  typedef logic [HW-1:0] half_t;

  // Closed-form stored contents: distinct halves so steering errors show.
  function automatic entry_t rom_word(input int unsigned idx, input entry_t seed);
    half_t hi;
    half_t lo;
    hi = 16'(idx * 37 + 11);
    lo = 16'(idx * 101 + 7);
    return {hi, lo} ^ seed;
  endfunction
endpackage

// File: rtl/dwr_array.sv
module dwr_array #(
  parameter int unsigned ADDR_W = 6,
  parameter dwr_pkg::entry_t SEED = 32'hC3A5_5A3C
) (
  input  logic                  clk,
  input  logic [ADDR_W-1:0]     addr_i,
  output dwr_pkg::entry_t       rd_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  dwr_pkg::entry_t rom_w [DEPTH];
  dwr_pkg::entry_t rd_q;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_fill
    assign rom_w[gi] = dwr_pkg::rom_word(gi, SEED);
  end

  // No reset on the read register so it can map onto block memory.
  always_ff @(posedge clk) begin
    rd_q <= rom_w[addr_i];
  end

  assign rd_o = rd_q;
endmodule

// File: rtl/dwr_steer.sv
module dwr_steer (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n_i,
  input  logic             oe_n_i,
  input  logic             wide_i,
  input  logic             lsb_i,
  input  dwr_pkg::entry_t  rd_i,
  output dwr_pkg::entry_t  data_o,
  output logic             lo_oe_o,
  output logic             mid_oe_o,
  output logic             top_oe_o
);
  import dwr_pkg::*;

  logic en_q;
  logic wide_q;
  logic lsb_q;
  logic primed_q;
  half_t low_lane;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      wide_q   <= 1'b0;
      lsb_q    <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      en_q     <= !ce_n_i && !oe_n_i;
      wide_q   <= wide_i;
      lsb_q    <= lsb_i;
      primed_q <= 1'b1;
    end
  end

  always_comb begin
    if (wide_q)     low_lane = rd_i[HW-1:0];
    else if (lsb_q) low_lane = rd_i[DW-1:HW];
    else            low_lane = rd_i[HW-1:0];
  end

  assign lo_oe_o  = en_q;
  assign mid_oe_o = en_q && wide_q;
  assign top_oe_o = en_q && wide_q;

  always_comb begin
    data_o = '0;
    if (en_q) begin
      data_o[HW-1:0] = low_lane;
      if (wide_q) data_o[DW-1:HW] = rd_i[DW-1:HW];
    end
  end

  AST_CE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && $past(ce_n_i)) |-> !(lo_oe_o || mid_oe_o || top_oe_o)); // R1
  AST_OE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && $past(!ce_n_i && oe_n_i)) |-> (data_o == '0 && !lo_oe_o)); // R2
  AST_WIDE_DRIVES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && $past(!ce_n_i && !oe_n_i && wide_i)) |-> (lo_oe_o && mid_oe_o && top_oe_o)); // R3
  AST_NARROW_UPPER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && $past(!wide_i)) |-> (!mid_oe_o && !top_oe_o && data_o[DW-1:HW] == '0)); // R5
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (data_o == '0 && !lo_oe_o)); // R8
endmodule

// File: rtl/dual_width_rom.sv
module dual_width_rom #(
  parameter int unsigned ADDR_W = 6,
  parameter logic [31:0] SEED   = 32'hC3A5_5A3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              lsb_i,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              wide_i,
  output logic [31:0]       data_o,
  output logic              lo_oe_o,
  output logic              mid_oe_o,
  output logic              top_oe_o
);
  dwr_pkg::entry_t rd_w;

  dwr_array #(.ADDR_W(ADDR_W), .SEED(SEED)) u_array (
    .clk    (clk),
    .addr_i (addr_i),
    .rd_o   (rd_w)
  );

  dwr_steer u_steer (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n_i   (ce_n_i),
    .oe_n_i   (oe_n_i),
    .wide_i   (wide_i),
    .lsb_i    (lsb_i),
    .rd_i     (rd_w),
    .data_o   (data_o),
    .lo_oe_o  (lo_oe_o),
    .mid_oe_o (mid_oe_o),
    .top_oe_o (top_oe_o)
  );
endmodule

// File: tb/sim_dual_width_rom.sv
module sim_dual_width_rom;
  localparam int unsigned PERIOD = 10;
  localparam int unsigned AW     = 6;
  localparam logic [31:0] SD     = 32'hC3A5_5A3C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          lsb = 1'b0, ce_n = 1'b1, oe_n = 1'b1, wide = 1'b0;
  logic [31:0]   data;
  logic          lo_oe, mid_oe, top_oe;
  int            n_cmp = 0, n_bad = 0;
  logic [34:0]   prev_obs;

  always #(PERIOD/2) clk = ~clk;

  dual_width_rom #(.ADDR_W(AW), .SEED(SD)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .lsb_i(lsb), .ce_n_i(ce_n),
    .oe_n_i(oe_n), .wide_i(wide), .data_o(data), .lo_oe_o(lo_oe),
    .mid_oe_o(mid_oe), .top_oe_o(top_oe)
  );

  function automatic logic [31:0] entry(input int unsigned a);
    logic [15:0] h, l;
    h = 16'(a * 37 + 11);
    l = 16'(a * 101 + 7);
    return {h, l} ^ SD;
  endfunction

  task automatic check(input string tag, input logic [34:0] act, input logic [34:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [34:0] observe();
    return {lo_oe, mid_oe, top_oe, data};
  endfunction

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset", observe(), 35'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after release idle", observe(), 35'h0);
    prev_obs = observe();
    for (int w = 0; w < 2; w++) begin
      for (int c = 0; c < 4; c++) begin
        for (int a = 0; a < (1 << AW); a++) begin
          for (int b = 0; b < 2; b++) begin
            logic [31:0] e, xd;
            logic        en, xl, xm, xt;
            string       tag;
            addr = AW'(a); lsb = b[0]; wide = w[0];
            ce_n = c[1]; oe_n = c[0];
            #1;
            check("R7 hold between edges", observe(), prev_obs);
            @(negedge clk);
            e  = entry(a);
            en = !c[1] && !c[0];
            xl = en; xm = en && w[0]; xt = xm;
            if (!en) xd = '0;
            else if (w[0]) xd = e;
            else xd = {16'h0, (b[0] ? e[31:16] : e[15:0])};
            if (c[1]) tag = "R1 deselected";
            else if (c[0]) tag = "R2 output disabled";
            else if (w[0] && b[0]) tag = "R6 wide ignores lsb";
            else if (w[0]) tag = "R3 wide read";
            else tag = "R4 narrow low lane";
            check(tag, {xl, 16'h0, xd[15:0]}, {lo_oe, 16'h0, data[15:0]});
            check(w[0] ? tag : "R5 narrow upper idle",
                  {xm, xt, xd[31:16]}, {mid_oe, top_oe, data[31:16]});
            prev_obs = observe();
          end
        end
      end
    end
    rst_n = 1'b0;
    #1;
    check("R8 async reset", observe(), 35'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule